// File: doc/BRIEF.md
# CRC-4 Multiframe Alignment Controller

This block finds and then watches the CRC-4 multiframe structure of an E1 stream once the basic frame aligner reports lock. The framer delivers one strobe per received basic frame. With the strobe come the first bit of timeslot 0 (the Si bit) and a flag that marks whether the frame carries the frame alignment signal. The controller looks for the six-bit multiframe alignment word carried in the odd frames. It declares multiframe lock when two copies of that word are seen at the same position modulo 16 frames within one 64-frame window. From then on it numbers the frames 0 to 15 and flags any alignment bit that arrives wrong.

When a window closes without lock, the controller asks the basic frame aligner for an offline re-search and waits for it to finish. It then opens a fresh window. A long timer of 3200 frames bounds the whole attempt. When that timer runs out, the controller declares CRC-to-non-CRC interworking. In that state it keeps hunting only when software allows it. All timers count frame strobes, so 16, 64 and 3200 frames stand for 2 ms, 8 ms and 400 ms.

The controller has five states. IDLE: the search is disabled or basic frame sync is absent. HUNT: the window is open and the controller looks for patterns. RESYNC: an offline basic frame re-search is in progress. INTERWORK: the long timer has expired. LOCKED: multiframe sync is held. Its transitions are:

- IDLE to HUNT, when enabled with basic frame sync.
- HUNT to LOCKED, on a second pattern at a matching position.
- HUNT to INTERWORK, when the long timer expires.
- HUNT to RESYNC, when the window expires.
- RESYNC to HUNT, when the re-search completes.
- RESYNC to INTERWORK, when the long timer expires.
- INTERWORK to LOCKED, on a matching pattern while continued search is enabled.
- Any state to IDLE, when the CRC enable or basic frame sync drops.

Top module: `crc4_mfa_ctrl`

## Requirements
- R1: After reset the outputs are oom=1, mfa_err=0, resync_req=0, iw_flag=0 and frm_num=0.
- R2: A pattern is counted only on a strobe with frm_fas=0 (NFAS frame). The current Si and the Si bits taken 2, 4, 6, 8 and 10 strobes earlier, read oldest first, must equal 0,0,1,0,1,1, which are the Si bits of frames 1, 3, 5, 7, 9 and 11. At least ten strobes must have arrived since the search (re)started. A corrupted copy does not count.
- R3: In HUNT, a pattern whose strobe count differs by a multiple of 16 from an earlier pattern in the same 64-strobe window causes lock. After that strobe, oom=0 and frm_num=11.
- R4: Two patterns whose positions differ by an amount that is not a multiple of 16 do not cause lock.
- R5: While locked, frm_num advances by one (mod 16) on each strobe and holds between strobes. While oom=1, frm_num is 0.
- R6: While locked, an Si bit that differs from the expected alignment bit in frame 1, 3, 5, 7, 9 or 11 raises mfa_err for exactly the one cycle after that strobe, and lock is kept. Si bits of even frames and of frames 13 and 15 never raise it.
- R7: If the 64th strobe of a window passes without lock, resync_req rises after that strobe. It stays high until a resync_done pulse arrives, which returns the block to HUNT with a fresh window.
- R8: On the 3200th strobe counted in HUNT and RESYNC since the search started without lock, iw_flag rises and resync_req falls. This takes priority over window expiry. resync_done has no effect in INTERWORK.
- R9: In INTERWORK with iw_search_en=0 no lock occurs. With iw_search_en=1 the search of R3 runs in successive 64-strobe windows. Lock then sets oom=0 and clears iw_flag.
- R10: When bfa_in_sync=0 or crc_en=0, the block is idle one cycle later (as in R1), and all timers and candidates are cleared. The block does not leave idle while either input is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_en | input | 1 | Enables the multiframe search |
| iw_search_en | input | 1 | Allows continued search in interworking |
| bfa_in_sync | input | 1 | Basic frame alignment is held |
| frm_stb | input | 1 | One-cycle strobe per received basic frame |
| frm_si | input | 1 | Si bit of the strobed frame |
| frm_fas | input | 1 | 1 when the strobed frame carries FAS |
| resync_done | input | 1 | Offline basic frame re-search has finished |
| oom | output | 1 | Out of multiframe alignment |
| mfa_err | output | 1 | One-cycle alignment-bit error pulse |
| resync_req | output | 1 | Offline basic frame re-search requested |
| iw_flag | output | 1 | CRC-to-non-CRC interworking declared |
| frm_num | output | 4 | Multiframe number of the last frame (0 when out of lock) |

## Verification
Some internal faults show up one strobe later. A phase mask that loses or invents a candidate makes oom fall on the wrong strobe, and a frame counter off by one points mfa_err at a CRC or E bit. Other faults take longer to appear. A window counter that is off moves the rise of resync_req away from the 64th strobe. A long timer that miscounts moves the rise of iw_flag away from the 3200th strobe, so that case needs one full run of the long timer. The bench checks every output after every strobe, so the first deviation shows at the strobe where it begins.

// File: rtl/crc4_mfa_pkg.sv
package crc4_mfa_pkg;

    localparam int MF_LEN     = 16;
    localparam int PW         = $clog2(MF_LEN);
    localparam int PAT_LEN    = 6;
    // Alignment bits, first entry (frame 1) in the MSB.
    localparam logic [PAT_LEN-1:0] MFA_PATTERN = 6'b001011;
    // Number of the frame that completes the alignment word.
    localparam int LOCK_FRAME = 2 * PAT_LEN - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_RESYNC,
        ST_INTERWORK,
        ST_LOCKED
    } mfa_state_t;

    // True when frame fn carries one of the alignment bits.
    function automatic logic is_align_frame(input logic [PW-1:0] fn);
        return fn[0] && (int'(fn) <= LOCK_FRAME);
    endfunction

    // Alignment bit expected in frame fn (only meaningful for odd fn <= 11).
    function automatic logic align_bit(input logic [PW-1:0] fn);
        int idx;
        idx = int'(fn) >> 1;
        if (idx < PAT_LEN)
            return MFA_PATTERN[PAT_LEN-1-idx];
        return 1'b0;
    endfunction

endpackage

// File: rtl/crc4_mfa_detect.sv
// Sliding matcher for the multiframe alignment word over the Si bit stream.
module crc4_mfa_detect
    import crc4_mfa_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          stb,
    input  logic          si,
    input  logic          fas,
    output logic          hit,
    output logic [PW-1:0] hit_phase
);
    localparam int HIST = 2 * PAT_LEN - 2;
    localparam int FW   = $clog2(HIST + 1);

    logic [HIST-1:0]    hist;
    logic [FW-1:0]      fill;
    logic [PW-1:0]      phase;
    logic [PAT_LEN-1:0] bit_ok;
    logic               fill_ok;

    assign fill_ok = (fill == FW'(HIST));

    // hist[b-1] holds the Si bit received b strobes before the current one.
    genvar j;
    generate
        for (j = 0; j < PAT_LEN; j++) begin : g_cmp
            if (j == PAT_LEN - 1) begin : g_now
                assign bit_ok[j] = (si == MFA_PATTERN[PAT_LEN-1-j]);
            end else begin : g_old
                assign bit_ok[j] = (hist[HIST-1-2*j] == MFA_PATTERN[PAT_LEN-1-j]);
            end
        end
    endgenerate

    assign hit       = stb && !fas && fill_ok && (&bit_ok);
    assign hit_phase = phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist  <= '0;
            fill  <= '0;
            phase <= '0;
        end else begin
            if (stb) begin
                hist  <= {hist[HIST-2:0], si};
                phase <= phase + 1'b1;
            end
            if (clr)
                fill <= '0;
            else if (stb && !fill_ok)
                fill <= fill + 1'b1;
        end
    end

endmodule

// File: rtl/crc4_mfa_track.sv
// Remembers which positions modulo 16 produced a pattern in the current window.
module crc4_mfa_track
    import crc4_mfa_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          hit,
    input  logic [PW-1:0] hit_phase,
    output logic          sync
);
    logic [MF_LEN-1:0] seen;

    assign sync = en && hit && seen[hit_phase];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen <= '0;
        else if (clr)
            seen <= '0;
        else if (en && hit)
            seen[hit_phase] <= 1'b1;
    end

endmodule

// File: rtl/crc4_mfa_timer.sv
// Frame-strobe counter that flags the strobe completing LIMIT strobes.
module crc4_mfa_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic stb,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expire = run && stb && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || expire)
            cnt <= '0;
        else if (run && stb)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/crc4_mfa_ctrl.sv
module crc4_mfa_ctrl
    import crc4_mfa_pkg::*;
#(
    parameter int WIN_FRAMES  = 64,
    parameter int LONG_FRAMES = 3200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crc_en,
    input  logic          iw_search_en,
    input  logic          bfa_in_sync,
    input  logic          frm_stb,
    input  logic          frm_si,
    input  logic          frm_fas,
    input  logic          resync_done,
    output logic          oom,
    output logic          mfa_err,
    output logic          resync_req,
    output logic          iw_flag,
    output logic [PW-1:0] frm_num
);
    mfa_state_t    state, state_nx;
    logic          run_ok;
    logic          searching;
    logic          hit;
    logic [PW-1:0] hit_phase;
    logic          sync;
    logic          exp_win, exp_long;
    logic          win_clr, mask_clr, det_clr, long_clr;
    logic          enter_hunt, enter_iw;
    logic [PW-1:0] fn_rx;

    assign run_ok     = crc_en && bfa_in_sync;
    assign searching  = (state == ST_HUNT) || ((state == ST_INTERWORK) && iw_search_en);
    assign enter_hunt = (state != ST_HUNT) && (state_nx == ST_HUNT);
    assign enter_iw   = (state != ST_INTERWORK) && (state_nx == ST_INTERWORK);

    assign win_clr  = (state == ST_IDLE) || enter_hunt || enter_iw ||
                      ((state == ST_INTERWORK) && !iw_search_en);
    assign mask_clr = win_clr || ((state == ST_INTERWORK) && exp_win);
    assign det_clr  = (state == ST_IDLE) || ((state == ST_RESYNC) && resync_done);
    assign long_clr = (state == ST_IDLE);

    crc4_mfa_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (det_clr),
        .stb       (frm_stb),
        .si        (frm_si),
        .fas       (frm_fas),
        .hit       (hit),
        .hit_phase (hit_phase)
    );

    crc4_mfa_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mask_clr),
        .en        (searching),
        .hit       (hit),
        .hit_phase (hit_phase),
        .sync      (sync)
    );

    crc4_mfa_timer #(.LIMIT(WIN_FRAMES)) u_win_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_clr),
        .run    (searching),
        .stb    (frm_stb),
        .expire (exp_win)
    );

    crc4_mfa_timer #(.LIMIT(LONG_FRAMES)) u_long_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (long_clr),
        .run    ((state == ST_HUNT) || (state == ST_RESYNC)),
        .stb    (frm_stb),
        .expire (exp_long)
    );

    // Next-state decision.
    always_comb begin
        state_nx = state;
        if (!run_ok) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_HUNT;
                ST_HUNT: begin
                    if (sync)          state_nx = ST_LOCKED;
                    else if (exp_long) state_nx = ST_INTERWORK;
                    else if (exp_win)  state_nx = ST_RESYNC;
                end
                ST_RESYNC: begin
                    if (exp_long)         state_nx = ST_INTERWORK;
                    else if (resync_done) state_nx = ST_HUNT;
                end
                ST_INTERWORK: begin
                    if (sync) state_nx = ST_LOCKED;
                end
                ST_LOCKED:    state_nx = ST_LOCKED;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Frame numbering and alignment-bit monitor.
    assign fn_rx = frm_num + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_num <= '0;
            mfa_err <= 1'b0;
        end else begin
            mfa_err <= 1'b0;
            if (state_nx == ST_LOCKED) begin
                if (state != ST_LOCKED) begin
                    frm_num <= PW'(LOCK_FRAME);
                end else if (frm_stb) begin
                    frm_num <= fn_rx;
                    mfa_err <= is_align_frame(fn_rx) && (frm_si != align_bit(fn_rx));
                end
            end else begin
                frm_num <= '0;
            end
        end
    end

    // Status decoded from the state register.
    assign oom        = (state != ST_LOCKED);
    assign resync_req = (state == ST_RESYNC);
    assign iw_flag    = (state == ST_INTERWORK);

endmodule

// File: rtl/crc4_mfa_chk.sv
module crc4_mfa_chk
    import crc4_mfa_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          crc_en,
    input logic          bfa_in_sync,
    input logic          frm_stb,
    input logic          oom,
    input logic          mfa_err,
    input logic          resync_req,
    input logic          iw_flag,
    input logic [PW-1:0] frm_num
);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bfa_in_sync || !crc_en) |=> (oom && !iw_flag && !resync_req && !mfa_err && frm_num == '0));

    p_err_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mfa_err |-> !oom);

    p_err_after_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mfa_err |-> $past(frm_stb));

    p_req_oom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |-> oom);

    p_iw_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iw_flag |-> (oom && !resync_req));

    p_iw_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_flag && crc_en && bfa_in_sync && !frm_stb) |=> iw_flag);

    p_frm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oom |-> (frm_num == '0));

    p_frm_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oom && frm_stb && crc_en && bfa_in_sync) |=> (frm_num == $past(frm_num) + 1'b1));

    p_frm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oom && !frm_stb && crc_en && bfa_in_sync) |=> $stable(frm_num));

    p_lock_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oom) |-> (frm_num == PW'(LOCK_FRAME) && $past(frm_stb)));

endmodule

bind crc4_mfa_ctrl crc4_mfa_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .crc_en      (crc_en),
    .bfa_in_sync (bfa_in_sync),
    .frm_stb     (frm_stb),
    .oom         (oom),
    .mfa_err     (mfa_err),
    .resync_req  (resync_req),
    .iw_flag     (iw_flag),
    .frm_num     (frm_num)
);

// File: tb/crc4_mfa_ctrl_tb.sv
`timescale 1ns/1ps
module crc4_mfa_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_en = 1'b0;
    logic       iw_search_en = 1'b0;
    logic       bfa_in_sync = 1'b1;
    logic       frm_stb = 1'b0;
    logic       frm_si = 1'b0;
    logic       frm_fas = 1'b0;
    logic       resync_done = 1'b0;
    logic       oom, mfa_err, resync_req, iw_flag;
    logic [3:0] frm_num;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    typedef struct packed {
        logic       oom;
        logic       err;
        logic [3:0] frm;
        logic       req;
        logic       iw;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    crc4_mfa_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_en       (crc_en),
        .iw_search_en (iw_search_en),
        .bfa_in_sync  (bfa_in_sync),
        .frm_stb      (frm_stb),
        .frm_si       (frm_si),
        .frm_fas      (frm_fas),
        .resync_done  (resync_done),
        .oom          (oom),
        .mfa_err      (mfa_err),
        .resync_req   (resync_req),
        .iw_flag      (iw_flag),
        .frm_num      (frm_num)
    );

    // Si bit transmitted in frame fn: alignment word in odd frames 1..11,
    // E bits (1) in 13 and 15, arbitrary CRC bits in even frames.
    function automatic bit si_of(input int fn);
        case (fn)
            1, 3, 7:       return 1'b0;
            5, 9, 11:      return 1'b1;
            13, 15:        return 1'b1;
            default:       return fn[1];
        endcase
    endfunction

    function automatic bit compare(input exp_t e, input string tag);
        exp_t got;
        got = '{oom: oom, err: mfa_err, frm: frm_num, req: resync_req, iw: iw_flag};
        n_vec++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got oom=%0b err=%0b frm=%0d req=%0b iw=%0b, expected oom=%0b err=%0b frm=%0d req=%0b iw=%0b",
                     tag, got.oom, got.err, got.frm, got.req, got.iw,
                     e.oom, e.err, e.frm, e.req, e.iw);
            return 1'b0;
        end
        return 1'b1;
    endfunction

    // Monitor: after each strobe edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            if (frm_stb) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard: strobe with no expectation queued");
                end else begin
                    void'(compare(exp_q.pop_front(), tag_q.pop_front()));
                end
            end
        end
    end

    // Driver: queue the expectation, then send one frame strobe.
    task automatic frame(input int fn, input bit flip, input bit eo, input bit ee,
                         input int ef, input bit er, input bit ei, input string tag);
        exp_q.push_back('{oom: eo, err: ee, frm: 4'(ef), req: er, iw: ei});
        tag_q.push_back(tag);
        @(negedge clk);
        frm_stb = 1'b1;
        frm_si  = si_of(fn) ^ flip;
        frm_fas = (fn % 2 == 0);
        @(negedge clk);
        frm_stb = 1'b0;
    endtask

    task automatic check_now(input bit eo, input int ef, input bit er, input bit ei, input string tag);
        @(negedge clk);
        void'(compare('{oom: eo, err: 1'b0, frm: 4'(ef), req: er, iw: ei}, tag));
    endtask

    task automatic restart_search();
        @(negedge clk) bfa_in_sync = 1'b0;
        @(negedge clk) bfa_in_sync = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk) resync_done = 1'b1;
        @(negedge clk) resync_done = 1'b0;
    endtask

    initial begin
        int fn;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_now(1, 0, 0, 0, "R1 reset state");

        // R10: CRC search disabled, valid patterns must not lock.
        for (int k = 0; k < 32; k++)
            frame(k % 16, 0, 1, 0, 0, 0, 0, "R10 idle with crc_en=0");
        crc_en = 1'b1;
        restart_search();

        // R2/R3: pattern in second multiframe corrupted; lock at 32-frame spacing.
        fn = 0;
        for (int k = 0; k <= 43; k++) begin
            frame(fn, k == 21, k < 43, 0, (k >= 43) ? 11 : 0, 0, 0,
                  (k == 27) ? "R2 corrupted word not counted" : "R3 lock at 32-frame spacing");
            fn = (fn + 1) % 16;
        end

        // R5/R6: locked numbering and alignment-bit errors.
        for (int k = 0; k < 48; k++) begin
            bit fl;
            fl = (k < 16) && (fn == 5 || fn == 13 || fn == 4 || fn == 11);
            frame(fn, fl, 0, fl && (fn == 5 || fn == 11), fn, 0, 0,
                  fl ? "R6 error pulse only on alignment frames" : "R5 frame numbering");
            fn = (fn + 1) % 16;
        end

        // R4: slip of two frames between the first and second pattern.
        restart_search();
        fn = 0;
        for (int k = 0; k <= 41; k++) begin
            frame(fn, 0, k < 41, 0, (k >= 41) ? 11 : 0, 0, 0,
                  (k == 25) ? "R4 mismatched position no lock" : "R4 lock on repeated position");
            fn = (k == 11) ? 14 : (fn + 1) % 16;
        end

        // R7: window expiry, hold, re-search completion, then lock.
        restart_search();
        for (int k = 0; k < 67; k++)
            frame(k % 2 == 0 ? 0 : 13, 0, 1, 0, 0, k >= 63, 0, "R7 window expiry");
        pulse_done();
        check_now(1, 0, 0, 0, "R7 resync_done returns to hunt");
        for (int k = 0; k <= 27; k++)
            frame(k % 16, 0, k < 27, 0, (k >= 27) ? 11 : 0, 0, 0, "R7 lock after re-search");

        // R8: long timer runs out over repeated re-searches.
        restart_search();
        for (int k = 0; k < 3200; k++) begin
            frame(k % 2 == 0 ? 0 : 13, 0, 1, 0, 0,
                  (k % 64 == 63) && (k < 3199), k >= 3199, "R8 long timer");
            if (k % 64 == 63) pulse_done();
        end
        check_now(1, 0, 0, 1, "R8 resync_done ignored in interworking");

        // R9: interworking without and with continued search.
        for (int k = 0; k < 48; k++)
            frame(k % 16, 0, 1, 0, 0, 0, 1, "R9 no search when disabled");
        @(negedge clk) iw_search_en = 1'b1;
        fn = 0;
        for (int k = 0; k <= 27; k++) begin
            frame(fn, 0, k < 27, 0, (k >= 27) ? 11 : 0, 0, k < 27, "R9 lock from interworking");
            fn = (fn + 1) % 16;
        end
        iw_search_en = 1'b0;

        // R10: loss of basic frame sync and CRC disable drop to idle.
        for (int k = 0; k < 4; k++) begin
            frame(fn, 0, 0, 0, fn, 0, 0, "R5 numbering before loss");
            fn = (fn + 1) % 16;
        end
        @(negedge clk) bfa_in_sync = 1'b0;
        check_now(1, 0, 0, 0, "R10 basic frame loss");
        @(negedge clk) bfa_in_sync = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= 27; k++)
            frame(k % 16, 0, k < 27, 0, (k >= 27) ? 11 : 0, 0, 0, "R10 fresh search after loss");
        @(negedge clk) crc_en = 1'b0;
        check_now(1, 0, 0, 0, "R10 crc disable");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d expectations left unchecked", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule